// File: doc/BRIEF.md
# Second-Order Digital Delta-Sigma Modulator

This block turns a stream of signed multi-bit samples into a single-bit stream whose running density follows the input. It is fully digital. It can drive a one-bit DAC, or it can act as a bit-exact model of a double-integrator noise-shaping loop. The loop has two accumulators in series. Each accumulator adds half of the difference between its input and the fed-back full-scale value. A sign test on the second accumulator produces the output bit, and that bit selects the feedback applied to both accumulators.

Every accepted strobe on `en_i` starts a sample period made of two clock cycles. In the first cycle the input, plus an optional pseudo-random dither value, is captured, and the sign decision is latched onto `bit_o`. In the second cycle both accumulators update using the latched decision. The accumulators are wider than the input by a number of guard bits, and they clip at their limits instead of wrapping. `sat_o` shows whether the most recent update clipped. The dither is meant to break up idle tones when the input is small and constant.

Top module: `dsm2_mod`

## Requirements
- R1: While `rst_ni` is low, and afterwards until the first accepted strobe, both accumulators hold zero and `bit_o` and `sat_o` are 0. The dither register holds 16'hACE1.
- R2: A strobe is accepted when `en_i` is high and the block is not in its update cycle. On the next edge `bit_o` becomes 1 if the second accumulator is greater than or equal to zero, and 0 otherwise. `bit_o` changes at no other time, so the first sample after reset gives 1.
- R3: In the cycle after an accepted strobe both accumulators update at once. With FS = 2^(IN_W-1) and feedback fb = +FS when `bit_o` is 1 and −FS when it is 0: acc1 += floor((x − fb)/2) and acc2 += floor((acc1_old − fb)/2).
- R4: A strobe that arrives during the update cycle is ignored. It changes neither the output, the accumulators nor the dither sequence.
- R5: The accumulators are IN_W+GUARD_W bits wide, with GUARD_W = 3 by default. A result outside the signed range of that width is clipped to the nearest limit.
- R6: `sat_o` is loaded at each update with whether either accumulator clipped, and it holds its value until the next update.
- R7: The dither register is a 16-bit maximal-length shift register. On each accepted strobe it shifts left and takes bit15^bit13^bit12^bit10 into bit 0. Its low DITH_W bits, read as a signed value, are added to `din_i` when `dith_en_i` is high at the strobe. The register value used is the one from before the shift.
- R8: With a constant input and dither on, the mean of the ±1 output over 4096 samples lies within 0.01 of din/FS.
- R9: Outside the update cycle both accumulators keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Sample strobe |
| din_i | input | IN_W | Signed input sample |
| dith_en_i | input | 1 | Adds dither to the sample |
| bit_o | output | 1 | Modulator output bit |
| sat_o | output | 1 | Last update clipped an accumulator |

## Verification
Some properties are checked every cycle by the assertions:
- the two-cycle phase sequence and the rejection of strobes during the update cycle;
- that the decision bit matches the sign of the second accumulator;
- that the accumulators and `sat_o` hold between updates;
- that a rising `sat_o` coincides with an accumulator sitting at a limit;
- that the dither register never reaches the all-zero state.

Other behaviour only the bench scenarios can show. The exact arithmetic of each update, including floor halving and the clipping values, shows up only as the bitstream and `sat_o` matching a reference model of the equations. Two things need long constant-input runs: that the dither sequence adds to the right sample, and that the bit density settles at din/FS.

// File: rtl/dsm2_pkg.sv
package dsm2_pkg;
  localparam int LFSR_W = 16;
  typedef logic [LFSR_W-1:0] lfsr_t;
  localparam lfsr_t LFSR_SEED = 16'hACE1;

  function automatic lfsr_t lfsr_step(lfsr_t s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/dsm2_lfsr.sv
module dsm2_lfsr
  import dsm2_pkg::*;
#(
  parameter int DITH_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  output logic [DITH_W-1:0] dith_o,
  output lfsr_t             state_o
);
  lfsr_t state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= LFSR_SEED;
    else if (step_i) state_q <= lfsr_step(state_q);
  end

  assign dith_o  = state_q[DITH_W-1:0];
  assign state_o = state_q;
endmodule

// File: rtl/dsm2_integ.sv
module dsm2_integ #(
  parameter int ACC_W = 15
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    upd_i,
  input  logic signed [ACC_W-1:0] in_i,
  input  logic signed [ACC_W-1:0] fb_i,
  output logic signed [ACC_W-1:0] acc_o,
  output logic                    clip_o
);
  localparam int EXT_W = ACC_W + 2;
  localparam logic signed [EXT_W-1:0] MAX_V = {3'b000, {(ACC_W-1){1'b1}}};
  localparam logic signed [EXT_W-1:0] MIN_V = {3'b111, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic signed [EXT_W-1:0] diff, half, sum;
  logic                    hit;

  always_comb begin
    diff = {{2{in_i[ACC_W-1]}}, in_i} - {{2{fb_i[ACC_W-1]}}, fb_i};
    half = diff >>> 1;  // floor of half-gain
    sum  = {{2{acc_q[ACC_W-1]}}, acc_q} + half;
    hit  = 1'b1;
    if (sum > MAX_V)      acc_d = MAX_V[ACC_W-1:0];
    else if (sum < MIN_V) acc_d = MIN_V[ACC_W-1:0];
    else begin
      acc_d = sum[ACC_W-1:0];
      hit   = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (upd_i) acc_q <= acc_d;
  end

  assign acc_o  = acc_q;
  assign clip_o = upd_i & hit;
endmodule

// File: rtl/dsm2_mod.sv
module dsm2_mod
  import dsm2_pkg::*;
#(
  parameter int IN_W    = 12,
  parameter int GUARD_W = 3,
  parameter int DITH_W  = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic signed [IN_W-1:0] din_i,
  input  logic                   dith_en_i,
  output logic                   bit_o,
  output logic                   sat_o
);
  localparam int ACC_W = IN_W + GUARD_W;
  localparam logic signed [ACC_W-1:0] FS_P = {{GUARD_W{1'b0}}, 1'b1, {(IN_W-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] FS_N = -FS_P;

  logic                    upd_q, bit_q, sat_q, accept;
  logic signed [ACC_W-1:0] x_q, x_d, din_x, dith_x, fb;
  logic [DITH_W-1:0]       dith;
  lfsr_t                   lfsr_q;
  logic signed [ACC_W-1:0] acc      [2];
  logic signed [ACC_W-1:0] stage_in [2];
  logic [1:0]              clip;

  assign accept = en_i & ~upd_q;

  dsm2_lfsr #(.DITH_W(DITH_W)) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (accept),
    .dith_o  (dith),
    .state_o (lfsr_q)
  );

  always_comb begin
    din_x  = {{GUARD_W{din_i[IN_W-1]}}, din_i};
    dith_x = {{(ACC_W-DITH_W){dith[DITH_W-1]}}, dith};
    x_d    = dith_en_i ? din_x + dith_x : din_x;
  end

  // phase 1: capture sample, latch decision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_q <= 1'b0;
      bit_q <= 1'b0;
      x_q   <= '0;
    end else begin
      upd_q <= accept;
      if (accept) begin
        bit_q <= ~acc[1][ACC_W-1];
        x_q   <= x_d;
      end
    end
  end

  assign fb          = bit_q ? FS_P : FS_N;
  assign stage_in[0] = x_q;
  assign stage_in[1] = acc[0];

  // phase 2: both integrators update with latched feedback
  for (genvar g = 0; g < 2; g++) begin : g_integ
    dsm2_integ #(.ACC_W(ACC_W)) u_integ (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .upd_i  (upd_q),
      .in_i   (stage_in[g]),
      .fb_i   (fb),
      .acc_o  (acc[g]),
      .clip_o (clip[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sat_q <= 1'b0;
    else if (upd_q) sat_q <= |clip;
  end

  assign bit_o = bit_q;
  assign sat_o = sat_q;
endmodule

// File: rtl/dsm2_mod_chk.sv
module dsm2_mod_chk #(
  parameter int ACC_W = 15
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    en_i,
  input logic                    upd_i,
  input logic                    bit_i,
  input logic                    sat_i,
  input logic signed [ACC_W-1:0] i1_i,
  input logic signed [ACC_W-1:0] i2_i,
  input logic [15:0]             lfsr_i
);
  localparam logic signed [ACC_W-1:0] HI = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] LO = {1'b1, {(ACC_W-1){1'b0}}};

  assert_phase_enter_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !upd_i) |=> upd_i);
  assert_strobe_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> !upd_i);
  assert_bit_sign_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !upd_i) |=> (bit_i == !$past(i2_i[ACC_W-1])));
  assert_bit_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && !upd_i) |=> $stable(bit_i));
  assert_acc_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> ($stable(i1_i) && $stable(i2_i)));
  assert_sat_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(sat_i));
  assert_sat_at_limit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sat_i) |-> (i1_i == HI || i1_i == LO || i2_i == HI || i2_i == LO));
  assert_lfsr_live_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_i != 16'h0000);
endmodule

bind dsm2_mod dsm2_mod_chk #(.ACC_W(ACC_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .upd_i  (upd_q),
  .bit_i  (bit_o),
  .sat_i  (sat_o),
  .i1_i   (acc[0]),
  .i2_i   (acc[1]),
  .lfsr_i (lfsr_q)
);

// File: tb/dsm2_mod_tb.sv
module dsm2_mod_tb_top;
  localparam int DITH_W = 4;
  localparam int IN_A = 12, GRD_A = 3;
  localparam int IN_B = 8,  GRD_B = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic                   en_a = 1'b0, dith_a = 1'b0, bit_a, sat_a;
  logic signed [IN_A-1:0] din_a = '0;
  logic                   en_b = 1'b0, dith_b = 1'b0, bit_b, sat_b;
  logic signed [IN_B-1:0] din_b = '0;

  dsm2_mod #(.IN_W(IN_A), .GUARD_W(GRD_A), .DITH_W(DITH_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en_a), .din_i(din_a),
    .dith_en_i(dith_a), .bit_o(bit_a), .sat_o(sat_a));

  dsm2_mod #(.IN_W(IN_B), .GUARD_W(GRD_B), .DITH_W(DITH_W)) dut_b_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en_b), .din_i(din_b),
    .dith_en_i(dith_b), .bit_o(bit_b), .sat_o(sat_b));

  int checks = 0, errors = 0;
  int m_i1 [2], m_i2 [2], m_lfsr [2];
  bit m_bit [2], m_sat [2];
  int sc_bad, sc_idx, sc_act, sc_exp, sc_n, ones, sat_seen;
  bit done = 1'b0;

  function automatic int clip_to(int v, int w);
    int hi = (1 << (w - 1)) - 1;
    int lo = -(1 << (w - 1));
    return (v > hi) ? hi : (v < lo) ? lo : v;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 2; k++) begin
      m_i1[k] = 0; m_i2[k] = 0; m_lfsr[k] = 'hACE1; m_bit[k] = 0; m_sat[k] = 0;
    end
  endtask

  task automatic model_step(int id, int x_in, bit den);
    int in_w = (id == 0) ? IN_A : IN_B;
    int acc_w = in_w + ((id == 0) ? GRD_A : GRD_B);
    int fs = 1 << (in_w - 1);
    int d, x, fb, n1, n2;
    bit y, fbit;
    y = (m_i2[id] >= 0);
    d = m_lfsr[id] & ((1 << DITH_W) - 1);
    if (d >= (1 << (DITH_W - 1))) d -= (1 << DITH_W);
    x = x_in + (den ? d : 0);
    fbit = m_lfsr[id][15] ^ m_lfsr[id][13] ^ m_lfsr[id][12] ^ m_lfsr[id][10];
    m_lfsr[id] = ((m_lfsr[id] << 1) & 'hFFFF) | int'(fbit);
    fb = y ? fs : -fs;
    n1 = m_i1[id] + ((x - fb) >>> 1);
    n2 = m_i2[id] + ((m_i1[id] - fb) >>> 1);
    m_sat[id] = (clip_to(n1, acc_w) != n1) || (clip_to(n2, acc_w) != n2);
    m_i1[id] = clip_to(n1, acc_w);
    m_i2[id] = clip_to(n2, acc_w);
    m_bit[id] = y;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    en_a = 0; en_b = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
  endtask

  // one sample period; called and returns at a falling edge
  task automatic sample(int id, int x, bit den, bit dbl);
    int act, exp_v;
    if (id == 0) begin en_a = 1; din_a = IN_A'(x); dith_a = den; end
    else         begin en_b = 1; din_b = IN_B'(x); dith_b = den; end
    @(negedge clk);
    if (!dbl) begin en_a = 0; en_b = 0; end
    @(negedge clk);
    en_a = 0; en_b = 0;
    model_step(id, x, den);
    act   = (id == 0) ? {sat_a, bit_a} : {sat_b, bit_b};
    exp_v = {m_sat[id], m_bit[id]};
    if (act != exp_v) begin
      if (sc_bad == 0) begin sc_idx = sc_n; sc_act = act; sc_exp = exp_v; end
      sc_bad++;
    end
    ones     += act & 1;
    sat_seen |= (act >> 1) & 1;
    sc_n++;
  endtask

  task automatic sc_clear();
    sc_bad = 0; sc_n = 0; ones = 0; sat_seen = 0;
  endtask

  task automatic sc_end(string req, string what);
    checks++;
    if (sc_bad != 0) begin
      errors++;
      $display("FAIL %s %s sample %0d {sat,bit} actual=%0d expected=%0d",
               req, what, sc_idx, sc_act, sc_exp);
    end
    sc_clear();
  endtask

  task automatic check_eq(string req, string what, int act, int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp_v);
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected<=200000 cycles", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    real mean, target;
    int xs [4] = '{0, 1000, -1500, 1500};
    sc_clear();
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    check_eq("R1", "bit_o in reset", int'(bit_a), 0);
    check_eq("R1", "sat_o in reset", int'(sat_a), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1", "bit_o after release", int'(bit_b), 0);

    // R2: zero accumulator gives 1 on first sample
    sample(0, -300, 0, 0);
    check_eq("R2", "first decision", int'(bit_a), 1);
    sc_end("R2", "first sample");

    // R3: sweep of constant inputs without dither
    do_reset();
    for (int v = -1800; v <= 1800; v += 300) begin
      for (int k = 0; k < 48; k++) sample(0, v, 0, 0);
      sc_end("R3", $sformatf("sweep x=%0d", v));
    end

    // R7: dither on, several levels
    do_reset();
    foreach (xs[j]) begin
      for (int k = 0; k < 128; k++) sample(0, xs[j] / 8 + j, 1, 0);
      sc_end("R7", $sformatf("dither x=%0d", xs[j] / 8 + j));
    end

    // R4: strobe held into the update cycle is dropped
    do_reset();
    for (int k = 0; k < 200; k++) sample(0, 321 - 3 * k, 1, k[0]);
    sc_end("R4", "double strobes");

    // R1: mid-run reset restarts the sequence
    do_reset();
    check_eq("R1", "bit_o after mid reset", int'(bit_a), 0);
    for (int k = 0; k < 64; k++) sample(0, 77, 1, 0);
    sc_end("R1", "restart after reset");

    // R8: long-run density
    foreach (xs[j]) begin
      do_reset();
      for (int k = 0; k < 4096; k++) sample(0, xs[j], 1, 0);
      mean   = (2.0 * ones - 4096.0) / 4096.0;
      target = xs[j] / 2048.0;
      checks++;
      if (mean - target > 0.01 || target - mean > 0.01) begin
        errors++;
        $display("FAIL R8 x=%0d mean actual=%f expected=%f", xs[j], mean, target);
      end
      sc_end("R3", $sformatf("long run x=%0d", xs[j]));
    end

    // R5/R6: narrow guard instance clips near full scale
    do_reset();
    for (int k = 0; k < 64; k++) sample(1, 127, 0, 0);
    check_eq("R6", "sat_o seen at x=127", (sat_seen != 0) ? 1 : 0, 1);
    sc_end("R5", "clip x=127");
    for (int k = 0; k < 64; k++) sample(1, -128, 1, 0);
    sc_end("R6", "clip x=-128");
    do_reset();
    for (int k = 0; k < 96; k++) sample(1, (k % 9) * 25 - 100, 1, 0);
    sc_end("R5", "varying narrow");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule